// File: doc/BRIEF.md
# Switch Register Access Bridge

This block lets a host processor reach the internal register file of an Ethernet switch core through a small 32-bit register window. Each switch register is named by an 8-bit page and an 8-bit offset. The host stages up to 64 bits of write data as two words and launches the access with a command word. The command's go bit stays set until the switch side answers. Read results come back as two words that the host fetches after go has cleared.

Before it may launch anything, the host must own the bridge. It raises a request bit in the control register and waits for the grant bit. Grant is withheld while another agent, signalled by `peer_busy`, holds the bridge. A reset bit in the command word aborts the bridge from any state.

The switch side is a plain request/acknowledge port. The bridge holds page, offset, write flag and 64-bit write data with `sw_valid` until the switch returns `sw_ack`, with read data on `sw_rdata` in that same cycle.

Top module: `srab_bridge`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every mapped register reads zero and `sw_valid` is low.
- R2: Writing the control register (offset 0x40) sets the request bit (bit 3) to data bit 3. The grant bit (bit 4, read-only) rises at least one clock after request, and only in a cycle where `peer_busy` is low. Once granted, it stays set while request stays set.
- R3: Clearing the request bit drops grant at the very next clock edge.
- R4: A command write (offset 0x2c) with bit 0 (go) set launches an access, but only while granted and idle. The launch stores page from bits 31:24, offset from bits 23:16 and the write flag from bit 1 (1 = write), and sets go. A command write without grant, or while go is set, changes nothing and launches nothing.
- R5: While go is set, `sw_valid` is high and page, offset, write flag and write data stay stable. The clock edge that sees `sw_ack` clears go and `sw_valid`.
- R6: When a read is acknowledged, `sw_rdata[31:0]` lands in offset 0x3c and `sw_rdata[63:32]` lands in offset 0x38. An acknowledged write leaves both read words unchanged.
- R7: The write-data low word (offset 0x34) and high word (offset 0x30) read back as written. At launch they are presented as `sw_wdata` = {high, low}.
- R8: A command write with bit 2 set, granted or not, aborts any pending access. It clears go, the request bit, grant, the stored command and both read words. Bit 2 always reads zero.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| peer_busy | input | 1 | Another agent holds the bridge |
| sw_valid | output | 1 | Switch access pending |
| sw_page | output | 8 | Switch register page |
| sw_offs | output | 8 | Switch register offset |
| sw_write | output | 1 | 1 = write access, 0 = read |
| sw_wdata | output | 64 | Write data for the switch |
| sw_ack | input | 1 | Switch acknowledges the pending access |
| sw_rdata | input | 64 | Read data, valid with sw_ack |

## Verification
Accesses are driven with distinct page/offset pairs and asymmetric data words. The patterns separate swapped high and low words, swapped page and offset fields, and a write flag that is taken from the wrong bit. A read, then a write, then another read shows that an acknowledged write does not disturb the read words. Switch response delays of zero and six cycles separate a go bit that clears on acknowledge from one that clears early. A second command issued during a slow access shows whether busy commands are dropped. Launches attempted without grant, with `peer_busy` held high, and after the reset bit show that ownership gates every access.

// File: rtl/srab_pkg.sv
// Package: shared offsets, bit positions and command record for the
// switch register access bridge. Offsets and bit positions are the
// software-visible layout that host code relies on.
package srab_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h2C;
    localparam logic [7:0] OFS_WDH  = 8'h30;
    localparam logic [7:0] OFS_WDL  = 8'h34;
    localparam logic [7:0] OFS_RDH  = 8'h38;
    localparam logic [7:0] OFS_RDL  = 8'h3C;
    localparam logic [7:0] OFS_CTRL = 8'h40;

    localparam int CMD_GO   = 0;
    localparam int CMD_WR   = 1;
    localparam int CMD_RST  = 2;
    localparam int CMD_OFFS = 16;
    localparam int CMD_PAGE = 24;
    localparam int CTL_REQ  = 3;
    localparam int CTL_GNT  = 4;

    localparam int FIELD_W = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] page;
        logic [FIELD_W-1:0] offs;
        logic               wr;
    } cmd_t;
endpackage

// File: rtl/srab_grant_ctl.sv
// Ownership arbiter: grants the bridge to the host while its request is
// held and no peer owns it. Assumes req comes from a register in the host
// decode and that peer_busy is synchronous to clk.
module srab_grant_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic req,
    input  logic peer_busy,
    output logic grant
);
    // Grant follows request one edge later, acquiring only when the peer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            grant <= 1'b0;
        else
            grant <= req && (grant || !peer_busy);
    end

    a_r2_grant_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(!peer_busy));

    a_r3_drop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !grant);
endmodule

// File: rtl/srab_sw_port.sv
// Switch-side sequencer: latches a launched command and write data, holds
// the request toward the switch until acknowledged, and captures read data.
// Assumes the switch answers with sw_ack for one cycle while sw_valid is high.
module srab_sw_port
    import srab_pkg::*;
#(
    parameter int XFER_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              launch,
    input  cmd_t              launch_cmd,
    input  logic [XFER_W-1:0] launch_wdata,
    input  logic              sw_ack,
    input  logic [XFER_W-1:0] sw_rdata,
    output logic              busy,
    output cmd_t              cmd_q,
    output logic              sw_valid,
    output logic [FIELD_W-1:0] sw_page,
    output logic [FIELD_W-1:0] sw_offs,
    output logic              sw_write,
    output logic [XFER_W-1:0] sw_wdata,
    output logic [XFER_W-1:0] rd_data
);
    logic [XFER_W-1:0] wdata_q;

    // Access state: launch, completion on acknowledge, abort on bridge reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cmd_q   <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            cmd_q   <= '0;
            rd_data <= '0;
        end else if (launch && !busy) begin
            busy    <= 1'b1;
            cmd_q   <= launch_cmd;
            wdata_q <= launch_wdata;
        end else if (busy && sw_ack) begin
            busy <= 1'b0;
            if (!cmd_q.wr)
                rd_data <= sw_rdata;
        end
    end

    // Switch-side view of the pending access.
    always_comb begin
        sw_valid = busy;
        sw_page  = cmd_q.page;
        sw_offs  = cmd_q.offs;
        sw_write = cmd_q.wr;
        sw_wdata = wdata_q;
    end

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !sw_ack && !abort) |=>
            (sw_valid && $stable(sw_page) && $stable(sw_offs) && $stable(sw_wdata) && $stable(sw_write)));

    a_r5_ack_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_ack && !abort) |=> !sw_valid);

    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sw_valid && rd_data == '0));

    a_r6_write_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_write && !abort) |=> $stable(rd_data));
endmodule

// File: rtl/srab_bridge.sv
// Top of the switch register access bridge: host register decode, write
// data staging, ownership request and read-back mux. The host port reads
// combinationally with no side effects; writes take effect at the clock edge.
module srab_bridge
    import srab_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic                peer_busy,
    output logic                sw_valid,
    output logic [FIELD_W-1:0]  sw_page,
    output logic [FIELD_W-1:0]  sw_offs,
    output logic                sw_write,
    output logic [2*WORD_W-1:0] sw_wdata,
    input  logic                sw_ack,
    input  logic [2*WORD_W-1:0] sw_rdata
);
    localparam int XFER_W = 2 * WORD_W;

    logic              req_q;
    logic              grant;
    logic              busy;
    logic [WORD_W-1:0] wd_lo;
    logic [WORD_W-1:0] wd_hi;
    logic [XFER_W-1:0] rd_data;
    cmd_t              cmd_q;
    cmd_t              new_cmd;
    logic              wr_cmd, wr_ctrl, wr_wdl, wr_wdh;
    logic              abort, launch;

    // Address decode of host writes.
    always_comb begin
        wr_cmd  = host_wr && (host_addr == ADDR_W'(OFS_CMD));
        wr_ctrl = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
        wr_wdl  = host_wr && (host_addr == ADDR_W'(OFS_WDL));
        wr_wdh  = host_wr && (host_addr == ADDR_W'(OFS_WDH));
        abort   = wr_cmd && host_wdata[CMD_RST];
        launch  = wr_cmd && !abort && host_wdata[CMD_GO] && grant && !busy;
        new_cmd.page = host_wdata[CMD_PAGE +: FIELD_W];
        new_cmd.offs = host_wdata[CMD_OFFS +: FIELD_W];
        new_cmd.wr   = host_wdata[CMD_WR];
    end

    // Ownership request bit, cleared by the bridge reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)
            req_q <= 1'b0;
        else if (wr_ctrl)
            req_q <= host_wdata[CTL_REQ];
    end

    // Write data staging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_lo <= '0;
            wd_hi <= '0;
        end else begin
            if (wr_wdl) wd_lo <= host_wdata;
            if (wr_wdh) wd_hi <= host_wdata;
        end
    end

    srab_grant_ctl u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (abort),
        .req       (req_q),
        .peer_busy (peer_busy),
        .grant     (grant)
    );

    srab_sw_port #(.XFER_W(XFER_W)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (abort),
        .launch       (launch),
        .launch_cmd   (new_cmd),
        .launch_wdata ({wd_hi, wd_lo}),
        .sw_ack       (sw_ack),
        .sw_rdata     (sw_rdata),
        .busy         (busy),
        .cmd_q        (cmd_q),
        .sw_valid     (sw_valid),
        .sw_page      (sw_page),
        .sw_offs      (sw_offs),
        .sw_write     (sw_write),
        .sw_wdata     (sw_wdata),
        .rd_data      (rd_data)
    );

    // Read-back mux; unmapped offsets read zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(OFS_CMD)) begin
            host_rdata[CMD_PAGE +: FIELD_W] = cmd_q.page;
            host_rdata[CMD_OFFS +: FIELD_W] = cmd_q.offs;
            host_rdata[CMD_WR]              = cmd_q.wr;
            host_rdata[CMD_GO]              = busy;
        end else if (host_addr == ADDR_W'(OFS_CTRL)) begin
            host_rdata[CTL_REQ] = req_q;
            host_rdata[CTL_GNT] = grant;
        end else if (host_addr == ADDR_W'(OFS_WDL)) begin
            host_rdata = wd_lo;
        end else if (host_addr == ADDR_W'(OFS_WDH)) begin
            host_rdata = wd_hi;
        end else if (host_addr == ADDR_W'(OFS_RDL)) begin
            host_rdata = rd_data[WORD_W-1:0];
        end else if (host_addr == ADDR_W'(OFS_RDH)) begin
            host_rdata = rd_data[XFER_W-1:WORD_W];
        end
    end

    a_r4_launch_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_valid) |-> $past(grant));

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!sw_valid && !grant));
endmodule

// File: tb/sim_srab_bridge.sv
// Scoreboard bench: launch tasks push the expected switch-side access,
// a monitor pops and compares each access as it appears on the port.
module sim_srab_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        peer_busy = 1'b0;
    logic        sw_valid;
    logic [7:0]  sw_page, sw_offs;
    logic        sw_write;
    logic [63:0] sw_wdata;
    logic        sw_ack = 1'b0;
    logic [63:0] sw_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    int resp_delay = 0;
    bit resp_en = 1'b1;
    bit done = 1'b0;
    bit mon_prev = 1'b0;

    typedef struct packed {
        logic [7:0]  page;
        logic [7:0]  offs;
        logic        wr;
        logic [63:0] wdata;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    srab_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .peer_busy(peer_busy),
        .sw_valid(sw_valid), .sw_page(sw_page), .sw_offs(sw_offs),
        .sw_write(sw_write), .sw_wdata(sw_wdata), .sw_ack(sw_ack), .sw_rdata(sw_rdata)
    );

    function automatic logic [63:0] model(input logic [7:0] p, input logic [7:0] o);
        return {p, o, ~p, ~o, 8'hC3, p ^ o, o, p};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // Launch a command; expect_go says whether the bridge should accept it.
    task automatic launch(input logic [31:0] cmd, input bit expect_go);
        exp_t e;
        if (expect_go) begin
            e.page = cmd[31:24]; e.offs = cmd[23:16]; e.wr = cmd[1];
            e.wdata = {u0.wd_hi, u0.wd_lo};
            exp_q.push_back(e);
        end
        wr(8'h2C, cmd);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rd(8'h2C, d);
            if (!d[0]) break;
        end
    endtask

    // Monitor: compares each new switch access against the scoreboard.
    always @(negedge clk) begin
        if (sw_valid && !mon_prev) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected switch access", {sw_page, sw_offs}, 16'h0);
                if ({sw_page, sw_offs} == 16'h0) begin nfail++; $display("FAIL R4 unexpected access actual=1 expected=0"); end
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R5 page/offset", {sw_page, sw_offs}, {e.page, e.offs});
                chk("R4 write flag", {63'd0, sw_write}, {63'd0, e.wr});
                if (e.wr) chk("R7 write data", sw_wdata, e.wdata);
            end
        end
        mon_prev = sw_valid;
    end

    // Switch responder model.
    initial begin
        forever begin
            @(negedge clk);
            if (sw_valid && resp_en && !sw_ack) begin
                repeat (resp_delay) @(negedge clk);
                if (sw_valid && resp_en) begin
                    sw_ack = 1'b1;
                    sw_rdata = model(sw_page, sw_offs);
                    @(negedge clk);
                    sw_ack = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(8'h2C, d); chk("R1 cmd", d, 0);
        rd(8'h40, d); chk("R1 ctrl", d, 0);
        rd(8'h3C, d); chk("R1 rd low", d, 0);
        rd(8'h38, d); chk("R1 rd high", d, 0);
        rd(8'h34, d); chk("R1 wd low", d, 0);
        chk("R1 sw_valid", sw_valid, 0);

        // R4: launch without grant is ignored
        launch(32'h0501_0001, 1'b0);
        repeat (2) @(negedge clk);
        rd(8'h2C, d); chk("R4 no-grant cmd", d, 0);
        chk("R4 no-grant sw_valid", sw_valid, 0);

        // R2: grant withheld while peer busy
        peer_busy = 1'b1;
        wr(8'h40, 32'h0000_0008);
        repeat (4) @(negedge clk);
        rd(8'h40, d); chk("R2 held off by peer", d, 32'h08);
        peer_busy = 1'b0;
        @(negedge clk);
        rd(8'h40, d); chk("R2 granted", d, 32'h18);
        peer_busy = 1'b1;
        @(negedge clk);
        rd(8'h40, d); chk("R2 grant kept", d, 32'h18);
        peer_busy = 1'b0;

        // R7: staging
        wr(8'h34, 32'h89AB_CDEF);
        wr(8'h30, 32'h0123_4567);
        rd(8'h34, d); chk("R7 wd low", d, 32'h89AB_CDEF);
        rd(8'h30, d); chk("R7 wd high", d, 32'h0123_4567);

        // R6: read access, delay 2
        resp_delay = 2;
        launch(32'h0510_0001, 1'b1);
        rd(8'h2C, d); chk("R4 go set", d, 32'h0510_0001);
        wait_idle();
        m = model(8'h05, 8'h10);
        rd(8'h3C, d); chk("R6 rd low", d, m[31:0]);
        rd(8'h38, d); chk("R6 rd high", d, m[63:32]);

        // R5/R6: write access leaves read words
        launch(32'h1234_0003, 1'b1);
        wait_idle();
        rd(8'h2C, d); chk("R5 go cleared", d, 32'h1234_0002);
        rd(8'h3C, d); chk("R6 rd low after write", d, m[31:0]);
        rd(8'h38, d); chk("R6 rd high after write", d, m[63:32]);

        // R5: zero-delay response
        resp_delay = 0;
        launch(32'hFF00_0001, 1'b1);
        wait_idle();
        m = model(8'hFF, 8'h00);
        rd(8'h3C, d); chk("R6 fast rd low", d, m[31:0]);
        rd(8'h38, d); chk("R6 fast rd high", d, m[63:32]);

        // R4: command while busy is ignored
        resp_delay = 6;
        launch(32'h2244_0001, 1'b1);
        launch(32'h7777_0003, 1'b0);
        rd(8'h2C, d); chk("R4 busy cmd kept", d, 32'h2244_0001);
        chk("R5 still valid", sw_valid, 1);
        wait_idle();
        m = model(8'h22, 8'h44);
        rd(8'h3C, d); chk("R6 slow rd low", d, m[31:0]);

        // R3: release drops grant next edge
        wr(8'h40, 32'h0);
        rd(8'h40, d); chk("R3 grant one edge later", d, 32'h10);
        @(negedge clk);
        rd(8'h40, d); chk("R3 grant dropped", d, 0);

        // R8: bridge reset aborts pending access
        wr(8'h40, 32'h08);
        repeat (2) @(negedge clk);
        resp_en = 1'b0;
        launch(32'h3300_0001, 1'b1);
        repeat (2) @(negedge clk);
        rd(8'h2C, d); chk("R8 pending before reset", d, 32'h3300_0001);
        wr(8'h2C, 32'h0000_0004);
        rd(8'h2C, d); chk("R8 cmd cleared", d, 0);
        rd(8'h40, d); chk("R8 ctrl cleared", d, 0);
        rd(8'h3C, d); chk("R8 rd low zero", d, 0);
        rd(8'h38, d); chk("R8 rd high zero", d, 0);
        chk("R8 sw_valid low", sw_valid, 0);
        resp_en = 1'b1;
        launch(32'h0102_0001, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 no launch after reset", sw_valid, 0);

        // R9: unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h35, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R9 read 0x00", d, 0);
        rd(8'h44, d); chk("R9 read 0x44", d, 0);
        rd(8'h34, d); chk("R9 wd low intact", d, 32'h89AB_CDEF);
        rd(8'h40, d); chk("R9 ctrl intact", d, 0);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule